// File: doc/BRIEF.md
# Instruction-Boundary Hold and Interrupt Sequencer

This block belongs to a microcoded processor's control unit. It decides what happens each time the microcode sequence of an instruction finishes, and it acts only when the end-of-instruction strobe is high. At that point it takes one of three paths:

- If the hold request was seen low, or a software breakpoint is requested, it suspends the processor.
- Otherwise, if an interrupt is pending, it dispatches to interrupt service. It reports the vector of the highest-priority pending request and clears that request.
- Otherwise, it lets the next instruction be fetched.

The hold request is sampled only when the bus address strobe falls. How the block leaves hold depends on how it entered. A hold taken from the pin ends as soon as the pin is sampled high again. A hold taken from a breakpoint ends only after the pin has been sampled low and then high. A one-cycle resume pulse marks the exit, and execution carries on from the instruction boundary where the hold was accepted.

Top module: `boundary_seq`

## Requirements
- R1: With `end_of_instr` low, the block takes none of its three paths: `fetch_next` and `svc_valid` stay low, `hold_ack` does not rise, and pending requests are left unchanged.
- R2: When a hold is sampled low at a boundary, the hold wins over pending interrupts. `hold_ack` rises one cycle after the boundary, and every pending bit stays set.
- R3: `hold_req_n` is sampled only in cycles where `strobe_fall` is high. A change of the pin without that strobe has no effect at the next boundary.
- R4: With no hold and at least one pending request, a boundary produces a one-cycle `svc_valid` one cycle later. `svc_vector` is the lowest set index (index 0 has the highest priority), and that pending bit is cleared in the same cycle.
- R5: With no hold, no breakpoint and nothing pending, a boundary produces a one-cycle `fetch_next` one cycle later.
- R6: A pin-entered hold ends one cycle after the pin is sampled high. In that cycle `hold_ack` falls and `resume` pulses for one cycle.
- R7: A breakpoint at a boundary with the pin sampled high enters hold. Sampling the pin high alone does not end this hold. It ends one cycle after a high sample that follows a low sample taken while in hold.
- R8: While `hold_ack` is high, boundaries and breakpoint requests are ignored: no fetch, no service, and pending bits are not cleared.
- R9: A request pulse on a line sets its bit in `irq_pending`, visible the next cycle. A pulse arriving in the same cycle as that bit's service clear leaves the bit set.
- R10: After reset, `hold_ack`, `resume`, `fetch_next` and `svc_valid` are low, `irq_pending` is zero, and the pin sample reads as not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_fall | input | 1 | High in a cycle where the address strobe falls; qualifies the hold sample |
| hold_req_n | input | 1 | Hold request, active low |
| brk_req | input | 1 | Software breakpoint request, looked at during a boundary |
| end_of_instr | input | 1 | Instruction sequence complete (boundary strobe) |
| irq_req | input | N_IRQ | Interrupt request pulses, one per line |
| fetch_next | output | 1 | One-cycle pulse: fetch the next instruction |
| svc_valid | output | 1 | One-cycle pulse: interrupt dispatch, with `svc_vector` valid |
| svc_vector | output | $clog2(N_IRQ) | Index of the request being serviced |
| irq_pending | output | N_IRQ | Pending request bits |
| hold_ack | output | 1 | High for the whole time the block is suspended |
| resume | output | 1 | One-cycle pulse on leaving hold |

## Verification
Boundary results are due one cycle after the boundary:

- `fetch_next`, `svc_valid`, `svc_vector`, the pending clear and the rise of `hold_ack` all change at the first clock edge after the cycle in which `end_of_instr` is high.
- A hold-pin change reaches the sample register at the edge that closes the `strobe_fall` cycle. An exit therefore shows at the edge after that: two edges after the strobe cycle for a pin-entered hold, provided the low sample was seen one edge earlier for a breakpoint-entered hold.

The driver queues each expected pulse before it applies the stimulus. The monitor pops the queue only when a pulse actually appears, sampling on the falling edge. Any early, late or extra pulse therefore shows up as a mismatch or an empty-queue failure. Level outputs are checked on the falling edge right after the edge that is due to change them.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Outcome chosen at an instruction boundary
    typedef enum logic [2:0] {
        PATH_IDLE,
        PATH_FETCH,
        PATH_SERVICE,
        PATH_HOLD_PIN,
        PATH_HOLD_BRK
    } path_e;

    // Suspend state, remembering how it was entered
    typedef enum logic [1:0] {
        HS_RUN,
        HS_PIN,
        HS_BRK
    } hold_st_e;

endpackage

// File: rtl/bseq_pending.sv
module bseq_pending #(
    parameter int N_REQ = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_REQ-1:0]           req,
    input  logic                       clr_en,
    input  logic [$clog2(N_REQ)-1:0]   clr_idx,
    output logic [N_REQ-1:0]           pend
);
    localparam int IDX_W = $clog2(N_REQ);

    logic [N_REQ-1:0] clr_mask;
    logic [N_REQ-1:0] pend_d, pend_q;

    for (genvar i = 0; i < N_REQ; i++) begin : g_bit
        assign clr_mask[i] = clr_en && (clr_idx == IDX_W'(i));
    end

    // A fresh request beats a clear of the same bit
    always_comb begin
        pend_d = (pend_q & ~clr_mask) | req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/bseq_prio_enc.sv
module bseq_prio_enc #(
    parameter int N_REQ = 16
) (
    input  logic [N_REQ-1:0]         pend,
    output logic                     any,
    output logic [$clog2(N_REQ)-1:0] idx
);
    localparam int IDX_W = $clog2(N_REQ);

    // Scan downward so the lowest set index is the one left in idx
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bseq_hold_ctl.sv
module bseq_hold_ctl
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_fall,
    input  logic hold_req_n,
    input  logic enter_pin,
    input  logic enter_brk,
    output logic hold_low,
    output logic hold_ack,
    output logic resume
);
    typedef struct packed {
        hold_st_e st;
        logic     seen_low;
        logic     smp;
        logic     resume;
    } hc_t;

    hc_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.resume = 1'b0;
        if (strobe_fall) r_d.smp = hold_req_n;
        unique case (r_q.st)
            HS_RUN: begin
                if (enter_pin) begin
                    r_d.st = HS_PIN;
                end else if (enter_brk) begin
                    r_d.st       = HS_BRK;
                    r_d.seen_low = 1'b0;
                end
            end
            HS_PIN: begin
                // level release
                if (r_q.smp) begin
                    r_d.st     = HS_RUN;
                    r_d.resume = 1'b1;
                end
            end
            HS_BRK: begin
                // needs low then high
                if (!r_q.smp) begin
                    r_d.seen_low = 1'b1;
                end else if (r_q.seen_low) begin
                    r_d.st       = HS_RUN;
                    r_d.seen_low = 1'b0;
                    r_d.resume   = 1'b1;
                end
            end
            default: r_d.st = HS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= HS_RUN;
            r_q.seen_low <= 1'b0;
            r_q.smp      <= 1'b1;
            r_q.resume   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_low = !r_q.smp;
    assign hold_ack = (r_q.st != HS_RUN);
    assign resume   = r_q.resume;
endmodule

// File: rtl/boundary_seq.sv
module boundary_seq
    import bseq_pkg::*;
#(
    parameter int N_IRQ = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe_fall,
    input  logic                     hold_req_n,
    input  logic                     brk_req,
    input  logic                     end_of_instr,
    input  logic [N_IRQ-1:0]         irq_req,
    output logic                     fetch_next,
    output logic                     svc_valid,
    output logic [$clog2(N_IRQ)-1:0] svc_vector,
    output logic [N_IRQ-1:0]         irq_pending,
    output logic                     hold_ack,
    output logic                     resume
);
    localparam int VEC_W = $clog2(N_IRQ);

    typedef struct packed {
        logic             fetch;
        logic             svc;
        logic [VEC_W-1:0] vec;
    } out_t;

    out_t       o_d, o_q;
    path_e      path;
    logic       boundary;
    logic       hold_low;
    logic       any_pend;
    logic [VEC_W-1:0] top_idx;

    bseq_pending #(.N_REQ(N_IRQ)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .clr_en  (path == PATH_SERVICE),
        .clr_idx (top_idx),
        .pend    (irq_pending)
    );

    bseq_prio_enc #(.N_REQ(N_IRQ)) u_prio (
        .pend (irq_pending),
        .any  (any_pend),
        .idx  (top_idx)
    );

    bseq_hold_ctl u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_fall (strobe_fall),
        .hold_req_n  (hold_req_n),
        .enter_pin   (path == PATH_HOLD_PIN),
        .enter_brk   (path == PATH_HOLD_BRK),
        .hold_low    (hold_low),
        .hold_ack    (hold_ack),
        .resume      (resume)
    );

    assign boundary = end_of_instr && !hold_ack;

    // Arbitration: pin hold, then breakpoint, then interrupt, then fetch
    always_comb begin
        path = PATH_IDLE;
        if (boundary) begin
            if (hold_low)      path = PATH_HOLD_PIN;
            else if (brk_req)  path = PATH_HOLD_BRK;
            else if (any_pend) path = PATH_SERVICE;
            else               path = PATH_FETCH;
        end
    end

    always_comb begin
        o_d       = o_q;
        o_d.fetch = (path == PATH_FETCH);
        o_d.svc   = (path == PATH_SERVICE);
        if (path == PATH_SERVICE) o_d.vec = top_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign fetch_next = o_q.fetch;
    assign svc_valid  = o_q.svc;
    assign svc_vector = o_q.vec;
endmodule

// File: rtl/boundary_seq_chk.sv
module boundary_seq_chk #(
    parameter int N_IRQ = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     end_of_instr,
    input logic [N_IRQ-1:0]         irq_req,
    input logic                     fetch_next,
    input logic                     svc_valid,
    input logic [$clog2(N_IRQ)-1:0] svc_vector,
    input logic [N_IRQ-1:0]         irq_pending,
    input logic                     hold_ack,
    input logic                     resume
);
    logic [N_IRQ-1:0] pend_prev;
    logic [N_IRQ-1:0] low_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_prev <= '0;
        else        pend_prev <= irq_pending;
    end

    assign low_mask = (N_IRQ'(1) << svc_vector) - N_IRQ'(1);

    // R1
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_next || svc_valid) |-> $past(end_of_instr) && !$past(hold_ack));

    // R5
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_next, svc_valid, resume}));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> !fetch_next && !svc_valid);

    // R4
    vec_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> pend_prev[svc_vector]);

    // R4
    vec_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> ((pend_prev & low_mask) == '0));

    // R6
    resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> $past(hold_ack) && !hold_ack);

    // R9
    req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |=> ((irq_pending & $past(irq_req)) == $past(irq_req)));
endmodule

bind boundary_seq boundary_seq_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .end_of_instr (end_of_instr),
    .irq_req      (irq_req),
    .fetch_next   (fetch_next),
    .svc_valid    (svc_valid),
    .svc_vector   (svc_vector),
    .irq_pending  (irq_pending),
    .hold_ack     (hold_ack),
    .resume       (resume)
);

// File: tb/boundary_seq_test.sv
module boundary_seq_test;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_fall = 1'b0;
    logic          hold_req_n = 1'b1;
    logic          brk_req = 1'b0;
    logic          end_of_instr = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          fetch_next, svc_valid, hold_ack, resume;
    logic [3:0]    svc_vector;
    logic [N-1:0]  irq_pending;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct { int kind; int vec; } exp_t; // kind 1 fetch, 2 service, 3 resume
    exp_t exp_q[$];

    always #2 clk = ~clk;

    boundary_seq #(.N_IRQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .strobe_fall(strobe_fall), .hold_req_n(hold_req_n),
        .brk_req(brk_req), .end_of_instr(end_of_instr), .irq_req(irq_req),
        .fetch_next(fetch_next), .svc_valid(svc_valid), .svc_vector(svc_vector),
        .irq_pending(irq_pending), .hold_ack(hold_ack), .resume(resume)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input int kind, input int vec);
        exp_t e;
        e.kind = kind;
        e.vec  = vec;
        exp_q.push_back(e);
    endtask

    // Monitor: pops an expectation whenever a pulse shows up
    always @(negedge clk) begin
        if (rst_n && (fetch_next || svc_valid || resume)) begin
            int k;
            exp_t e;
            k = fetch_next ? 1 : (svc_valid ? 2 : 3);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected pulse kind", k, 0);
            end else begin
                e = exp_q.pop_front();
                chk(k == e.kind, "R4/R5/R6 pulse kind", k, e.kind);
                if (k == 2) chk(int'(svc_vector) == e.vec, "R4 vector", int'(svc_vector), e.vec);
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic set_hold(input logic v);
        hold_req_n  = v;
        strobe_fall = 1'b1;
        cyc();
        strobe_fall = 1'b0;
    endtask

    task automatic boundary(input logic brk, input int kind, input int vec, input logic [N-1:0] irq);
        if (kind != 0) push(kind, vec);
        end_of_instr = 1'b1;
        brk_req      = brk;
        irq_req      = irq;
        cyc();
        end_of_instr = 1'b0;
        brk_req      = 1'b0;
        irq_req      = '0;
    endtask

    task automatic pulse_irq(input logic [N-1:0] v);
        irq_req = v;
        cyc();
        irq_req = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R10 reset state
        chk(!hold_ack && !resume && !fetch_next && !svc_valid, "R10 outputs idle", hold_ack, 0);
        chk(irq_pending == '0, "R10 pending", irq_pending, 0);

        // R5 nothing pending
        boundary(1'b0, 1, 0, '0);

        // R9 pulses set bits; R4 priority order
        pulse_irq(16'h0220);
        chk(irq_pending == 16'h0220, "R9 pending set", irq_pending, 16'h0220);
        boundary(1'b0, 2, 5, '0);
        chk(irq_pending == 16'h0200, "R4 bit cleared", irq_pending, 16'h0200);
        boundary(1'b0, 2, 9, '0);
        boundary(1'b0, 1, 0, '0);

        // R1 no boundary: nothing happens
        pulse_irq(16'h0008);
        repeat (3) cyc();
        chk(irq_pending == 16'h0008, "R1 pending untouched", irq_pending, 16'h0008);
        chk(!hold_ack, "R1 no hold", hold_ack, 0);

        // R3 pin low without the strobe is not sampled
        hold_req_n = 1'b0;
        cyc();
        boundary(1'b0, 2, 3, '0);
        chk(!hold_ack, "R3 unsampled pin ignored", hold_ack, 0);

        // R2 hold beats a pending interrupt
        pulse_irq(16'h0080);
        set_hold(1'b0);
        boundary(1'b0, 0, 0, '0);
        chk(hold_ack, "R2 hold entered", hold_ack, 1);
        chk(irq_pending == 16'h0080, "R2 interrupt kept", irq_pending, 16'h0080);

        // R8 boundaries ignored while held
        boundary(1'b1, 0, 0, '0);
        boundary(1'b0, 0, 0, '0);
        chk(hold_ack, "R8 still held", hold_ack, 1);
        chk(irq_pending == 16'h0080, "R8 pending kept", irq_pending, 16'h0080);

        // R6 pin release ends the hold
        push(3, 0);
        set_hold(1'b1);
        chk(hold_ack, "R6 not yet released", hold_ack, 1);
        cyc();
        chk(!hold_ack, "R6 released", hold_ack, 0);
        boundary(1'b0, 2, 7, '0);

        // R7 breakpoint entry, needs a low pulse to exit
        boundary(1'b1, 0, 0, '0);
        chk(hold_ack, "R7 breakpoint hold", hold_ack, 1);
        set_hold(1'b1);
        cyc();
        cyc();
        chk(hold_ack, "R7 high alone keeps hold", hold_ack, 1);
        set_hold(1'b0);
        chk(hold_ack, "R7 low keeps hold", hold_ack, 1);
        push(3, 0);
        set_hold(1'b1);
        cyc();
        chk(!hold_ack, "R7 pulse releases", hold_ack, 0);
        boundary(1'b0, 1, 0, '0);

        // R9 set and clear in the same cycle
        pulse_irq(16'h0004);
        boundary(1'b0, 2, 2, 16'h0004);
        chk(irq_pending == 16'h0004, "R9 request not lost", irq_pending, 16'h0004);
        boundary(1'b0, 2, 2, '0);
        chk(irq_pending == '0, "R9 cleared after", irq_pending, 0);

        repeat (4) cyc();
        chk(exp_q.size() == 0, "R4/R5/R6 missing pulses", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule